// File: doc/BRIEF.md
# Factorial Register Unit

This block is a small memory-mapped register unit for a simple peripheral. Software reaches it over a plain register bus with an address, write data, a write strobe, a read strobe and an access-size code. It holds a fixed identification word, a liveness register that reads back the complement of what was last written, a factorial register, and a status register.

Writing an operand to the factorial register starts an iterative engine that performs one multiply per clock and leaves the result in the same register. The status register shows a busy flag while the engine runs and holds an enable bit. When that bit is set, finishing a computation sends a one-cycle raise pulse with a fixed code to an external interrupt controller. Software polls the busy flag, or waits for the interrupt, before it reads the result.

Top module: `mmio_fact_unit`

## Requirements
- R1: A legal read of offset 0x00 returns {VER_MAJOR, VER_MINOR, 8'h00, 8'hED}. Writes to offset 0x00 have no effect.
- R2: A legal read of offset 0x04 returns the bitwise complement of the last value legally written there. After reset it reads 0xFFFFFFFF.
- R3: A legal write of n to offset 0x08 sets status bit 0 (mask 0x01). When that bit clears, offset 0x08 holds n! modulo 2^32, and both 0! and 1! give 1. The factorial register reads 0 after reset.
- R4: The engine does one multiply per cycle. For n <= 33, status bit 0 reads 1 for exactly max(n,1) consecutive cycles after the write. For any larger n the result is 0 and the bit clears within 41 cycles.
- R5: A write to offset 0x08 while status bit 0 is set is ignored. A read of offset 0x08 while busy returns the partial product: 1 in the first busy cycle, then the product of the operand's top factors so far.
- R6: Status bit 7 (mask 0x80) is read/write. Writes to every other status bit are dropped, and bit 0 always reflects the engine.
- R7: When a computation finishes with status bit 7 set, irq_raise is high for exactly one cycle with irq_value = 0x00000001, one cycle after status bit 0 clears. With bit 7 clear there is no pulse. irq_value is 0 whenever irq_raise is low.
- R8: Size codes are bus_size = log2(bytes): 0 = 1 B, 1 = 2 B, 2 = 4 B, 3 = 8 B. Below offset 0x80 only code 2 is legal; from 0x80 up, codes 2 and 3 are legal. An illegal write is ignored and an illegal read returns 0.
- R9: bus_rdata is registered and is loaded on the clock edge that samples bus_rd. Offsets that map to no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_size | input | 2 | Access size code, log2 of bytes |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_raise | output | 1 | One-cycle interrupt raise request |
| irq_value | output | 32 | Interrupt code carried with irq_raise |

## Verification
The hardest states to reach from the ports are the engine's transient ones. The partial product is visible for only one cycle per factor, and a second write lands only while the first computation is still running. The stimulus reaches both by issuing a read or a write on the cycle right after the start write, and then by polling the status flag once per cycle, so the busy length is measured to the cycle. Large operands exercise the early stop on a zero product. Random operands, enable settings and illegal size codes are mixed with these directed cases.

// File: rtl/mfu_pkg.sv
package mfu_pkg;

    localparam int DW = 32;

    typedef enum logic [1:0] {
        SZ_1B = 2'd0,
        SZ_2B = 2'd1,
        SZ_4B = 2'd2,
        SZ_8B = 2'd3
    } acc_size_e;

    localparam logic [7:0] OFS_ID       = 8'h00;
    localparam logic [7:0] OFS_LIVE     = 8'h04;
    localparam logic [7:0] OFS_FACT     = 8'h08;
    localparam logic [7:0] OFS_STAT     = 8'h20;
    localparam logic [7:0] NARROW_LIMIT = 8'h80;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_IEN_BIT  = 7;

    localparam logic [DW-1:0] IRQ_FACT_CODE = 32'h0000_0001;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ID,
        SEL_LIVE,
        SEL_FACT,
        SEL_STAT
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     wr;
        logic     rd;
    } bus_op_t;

    typedef enum logic {
        ENG_IDLE,
        ENG_RUN
    } eng_state_e;

    function automatic logic [DW-1:0] make_id(input logic [7:0] maj, input logic [7:0] mnr);
        return {maj, mnr, 8'h00, 8'hED};
    endfunction

    function automatic logic size_ok(input logic narrow, input acc_size_e sz);
        if (narrow) return (sz == SZ_4B);
        return (sz == SZ_4B) || (sz == SZ_8B);
    endfunction

endpackage

// File: rtl/mfu_decode.sv
module mfu_decode
    import mfu_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              wr,
    input  logic              rd,
    output bus_op_t           op
);
    localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(OFS_ID);
    localparam logic [ADDR_W-1:0] A_LIVE = ADDR_W'(OFS_LIVE);
    localparam logic [ADDR_W-1:0] A_FACT = ADDR_W'(OFS_FACT);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_LIM  = ADDR_W'(NARROW_LIMIT);

    logic     narrow;
    logic     legal;
    reg_sel_e sel;

    assign narrow = (addr < A_LIM);
    assign legal  = size_ok(narrow, acc_size_e'(size));

    always_comb begin
        sel = SEL_NONE;
        if (legal) begin
            case (addr)
                A_ID:    sel = SEL_ID;
                A_LIVE:  sel = SEL_LIVE;
                A_FACT:  sel = SEL_FACT;
                A_STAT:  sel = SEL_STAT;
                default: sel = SEL_NONE;
            endcase
        end
    end

    always_comb begin
        op.sel = sel;
        op.wr  = wr && (sel != SEL_NONE) && (sel != SEL_ID);
        op.rd  = rd;
    end
endmodule

// File: rtl/mfu_fact_engine.sv
module mfu_fact_engine
    import mfu_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] operand,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] acc
);
    eng_state_e   state;
    logic [W-1:0] cnt;
    logic         finish;

    // Stop at the last factor, or as soon as the wrapped product is zero.
    assign finish = (cnt <= W'(1)) || (acc == '0);
    assign busy   = (state == ENG_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ENG_IDLE;
            acc   <= '0;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ENG_IDLE: begin
                    if (start) begin
                        acc   <= W'(1);
                        cnt   <= operand;
                        state <= ENG_RUN;
                    end
                end
                ENG_RUN: begin
                    if (finish) begin
                        state <= ENG_IDLE;
                        done  <= 1'b1;
                    end else begin
                        acc <= acc * cnt;
                        cnt <= cnt - W'(1);
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // R5: the register front end must never start a busy engine
    p_start_idle_r5: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R4: the factor count moves down by one on every busy cycle that continues
    p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(finish)) |-> (cnt == $past(cnt) - W'(1)));

    // R3: completion comes exactly once, as the engine leaves its busy state
    p_done_edge_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
endmodule

// File: rtl/mmio_fact_unit.sv
module mmio_fact_unit
    import mfu_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter logic [7:0] VER_MAJOR = 8'h01,
    parameter logic [7:0] VER_MINOR = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_size,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_raise,
    output logic [DW-1:0]     irq_value
);
    localparam logic [DW-1:0] ID_WORD = make_id(VER_MAJOR, VER_MINOR);

    bus_op_t       op;
    logic          eng_busy;
    logic          eng_done;
    logic          eng_start;
    logic [DW-1:0] eng_acc;
    logic [DW-1:0] live_q;
    logic          ien_q;
    logic          irq_q;
    logic [DW-1:0] rdata_q;
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] stat_word;

    mfu_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .size (bus_size),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .op   (op)
    );

    assign eng_start = op.wr && (op.sel == SEL_FACT) && !eng_busy;

    mfu_fact_engine #(.W(DW)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .start   (eng_start),
        .operand (bus_wdata),
        .busy    (eng_busy),
        .done    (eng_done),
        .acc     (eng_acc)
    );

    always_comb begin
        stat_word                = '0;
        stat_word[STAT_BUSY_BIT] = eng_busy;
        stat_word[STAT_IEN_BIT]  = ien_q;
    end

    always_comb begin
        case (op.sel)
            SEL_ID:   rd_mux = ID_WORD;
            SEL_LIVE: rd_mux = live_q;
            SEL_FACT: rd_mux = eng_acc;
            SEL_STAT: rd_mux = stat_word;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q  <= '1;
            ien_q   <= 1'b0;
            irq_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            irq_q <= eng_done && ien_q;
            if (op.rd) rdata_q <= rd_mux;
            if (op.wr && op.sel == SEL_LIVE) live_q <= ~bus_wdata;
            if (op.wr && op.sel == SEL_STAT) ien_q <= bus_wdata[STAT_IEN_BIT];
        end
    end

    assign bus_rdata = rdata_q;
    assign irq_raise = irq_q;
    assign irq_value = irq_q ? IRQ_FACT_CODE : '0;

    // R1: a legal identification read loads the fixed word
    p_id_read_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(OFS_ID) && bus_size == 2'd2) |=> (bus_rdata == ID_WORD));

    // R8: a narrow-region read of a size other than four bytes returns zero
    p_bad_size_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr < ADDR_W'(NARROW_LIMIT) && bus_size != 2'd2) |=> (bus_rdata == '0));

    // R7: a raise pulse comes one cycle after busy cleared and lasts one cycle
    p_irq_after_busy_r7: assert property (@(posedge clk) disable iff (rst)
        irq_raise |-> ($past(eng_busy, 2) && !$past(eng_busy)));

    p_irq_single_r7: assert property (@(posedge clk) disable iff (rst)
        irq_raise |=> !irq_raise);
endmodule

// File: tb/tb_mmio_fact_unit.sv
module tb_mmio_fact_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_rdata;
    logic        irq_raise;
    logic [31:0] irq_value;

    int n_chk = 0;
    int n_err = 0;
    int irq_cnt = 0;
    int irq_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mmio_fact_unit dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_size(bus_size),
        .bus_rdata(bus_rdata), .irq_raise(irq_raise), .irq_value(irq_value)
    );

    always @(negedge clk) begin
        if (!rst && irq_raise) begin
            irq_cnt++;
            if (irq_value !== 32'h1) irq_bad++;
        end
        if (!rst && !irq_raise && irq_value !== 32'h0) irq_bad++;
    end

    function automatic logic [31:0] exp_fact(input logic [31:0] n);
        logic [31:0] p = 32'd1;
        if (n >= 32'd34) return 32'd0;
        for (int i = 2; i <= int'(n); i++) p = p * 32'(i);
        return p;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz);
        bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] q);
        bus_addr = a; bus_size = sz; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        q = bus_rdata;
    endtask

    // Start a computation, count busy cycles by polling, check result and interrupt.
    task automatic run_fact(input logic [31:0] n, input bit ien);
        logic [31:0] q;
        int busy_cyc = 0;
        int irq0;
        do_wr(8'h20, ien ? 32'h80 : 32'h0, 2'd2);
        irq0 = irq_cnt;
        do_wr(8'h08, n, 2'd2);
        for (int k = 0; k < 100; k++) begin
            do_rd(8'h20, 2'd2, q);
            if (q[0]) busy_cyc++;
            else break;
        end
        do_rd(8'h08, 2'd2, q);
        check("R3 factorial result", q, exp_fact(n));
        if (n <= 32'd33)
            check("R4 busy length", 32'(busy_cyc), (n <= 32'd1) ? 32'd1 : n);
        else
            check("R4 busy bound", 32'(busy_cyc <= 41), 32'd1);
        check("R7 irq pulses", 32'(irq_cnt - irq0), ien ? 32'd1 : 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] q;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // Reset state
        do_rd(8'h04, 2'd2, q); check("R2 reset liveness", q, 32'hFFFF_FFFF);
        do_rd(8'h08, 2'd2, q); check("R3 reset factorial", q, 32'h0);
        do_rd(8'h20, 2'd2, q); check("R6 reset status", q, 32'h0);
        check("R7 no irq at reset", 32'(irq_cnt), 32'd0);

        // Identification
        do_rd(8'h00, 2'd2, q); check("R1 id word", q, 32'h0100_00ED);
        do_wr(8'h00, 32'h1234_5678, 2'd2);
        do_rd(8'h00, 2'd2, q); check("R1 id write ignored", q, 32'h0100_00ED);

        // Liveness
        do_wr(8'h04, 32'hA5A5_0F0F, 2'd2);
        do_rd(8'h04, 2'd2, q); check("R2 complement", q, 32'h5A5A_F0F0);

        // Status write masking
        do_wr(8'h20, 32'hFFFF_FFFF, 2'd2);
        do_rd(8'h20, 2'd2, q); check("R6 only enable kept", q, 32'h80);
        do_wr(8'h20, 32'h0000_007F, 2'd2);
        do_rd(8'h20, 2'd2, q); check("R6 enable cleared", q, 32'h0);

        // Illegal sizes and unmapped offsets
        do_wr(8'h04, 32'h0000_0001, 2'd0);
        do_rd(8'h04, 2'd2, q); check("R8 narrow write ignored", q, 32'h5A5A_F0F0);
        do_rd(8'h04, 2'd3, q); check("R8 8-byte read below 0x80", q, 32'h0);
        do_rd(8'h00, 2'd1, q); check("R8 2-byte id read", q, 32'h0);
        do_wr(8'h08, 32'd5, 2'd1);
        do_rd(8'h20, 2'd2, q); check("R8 bad-size start ignored", q, 32'h0);
        do_rd(8'h10, 2'd2, q); check("R9 unmapped low", q, 32'h0);
        do_rd(8'h90, 2'd3, q); check("R9 unmapped high", q, 32'h0);

        // Directed factorial corners
        run_fact(32'd0, 1'b1);
        run_fact(32'd1, 1'b0);
        run_fact(32'd2, 1'b1);
        run_fact(32'd12, 1'b1);
        run_fact(32'd13, 1'b0);
        run_fact(32'd33, 1'b1);
        run_fact(32'd34, 1'b1);
        run_fact(32'hFFFF_FFFF, 1'b1);

        // Partial product and write while busy
        do_wr(8'h20, 32'h0, 2'd2);
        do_wr(8'h08, 32'd10, 2'd2);
        do_rd(8'h08, 2'd2, q); check("R5 partial first", q, 32'd1);
        do_rd(8'h08, 2'd2, q); check("R5 partial second", q, 32'd10);
        do_wr(8'h08, 32'd3, 2'd2);
        repeat (20) @(negedge clk);
        do_rd(8'h08, 2'd2, q); check("R5 busy write ignored", q, 32'd3628800);

        // Random mix
        for (int it = 0; it < 60; it++) begin
            logic [31:0] n;
            logic [31:0] v;
            n = (($urandom % 8) == 0) ? $urandom : ($urandom % 34);
            run_fact(n, 1'($urandom));
            v = $urandom;
            do_wr(8'h04, v, 2'd2);
            do_wr(8'h04, ~v, 2'(($urandom % 2) * 3));
            do_rd(8'h04, 2'd2, q); check("R2 random complement", q, ~v);
        end

        check("R7 irq value", 32'(irq_bad), 32'd0);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule